// File: doc/BRIEF.md
# Buffer Memory Self-Test Controller

This block fills a byte-wide buffer of 8192 locations with a generated test pattern, writing every location exactly once in ascending address order, one byte per clock. While it writes, it folds each byte into a 16-bit one's-complement checksum. Software can then compare that checksum against one produced by a separate engine that reads the same memory back.

The host reaches the block through four byte-wide registers: a control/status byte, a seed byte, and the high and low checksum bytes. A start request launches a run, and the busy flag drops by itself once the last byte is written. Three fill modes are available: a Galois LFSR sequence, each location's own low address byte, and a seed pattern rotated left by a programmable amount after every write. A port-swap flag is passed straight to the memory arbiter.

Top module: `memSelfTest`

## Requirements
- R1: After reset the control register reads 0x00, the seed reads 0x00, the checksum reads 0xFFFF, memWe is low and swapPorts is low.
- R2: Register map on regAddr: 0 is control, 1 is seed, 2 is checksum high byte, 3 is checksum low byte. Control bits are 7 = start/busy, 6 = test enable, 5:4 = fill mode, 3 = port swap, 2:0 = shift amount. Reads are combinational.
- R3: A control write with bit 7 and bit 6 set, a mode other than 11, and no run in progress starts a run. From the next cycle, memWe is high for exactly 8192 cycles, and memAddr steps 0,1,…,8191, one location per cycle.
- R4: Control bit 7 reads 1 while a run is in progress. It clears by itself on the edge that completes the write to location 8191.
- R5: Mode 00 (pseudo-random): the first byte is the seed, or 0x01 when the seed is zero. Each following byte is the previous one advanced once by a right-shifting Galois LFSR with feedback mask 0xB8 (x^8+x^6+x^5+x^4+1).
- R6: Mode 01 (address fill): each location receives the low 8 bits of its own address.
- R7: Mode 10 (pattern shift): the first byte is the seed. Each following byte is the previous one rotated left by the shift amount (0 to 7).
- R8: The shift amount has no effect in modes 00 and 01.
- R9: The checksum is the bitwise inverse of the one's-complement sum of 16-bit words. Each word takes its even-address byte as the high byte and its odd-address byte as the low byte. The final value is readable once busy reads 0.
- R10: A start request is ignored when test enable is 0 or when the mode is 11: no write occurs and busy stays 0.
- R11: While a run is in progress, writes to the control register are ignored entirely. This includes a new start request and changes to the mode, shift amount or port swap, so the run's configuration stays fixed.
- R12: swapPorts follows the stored port-swap bit whether or not a run is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| memAddr | output | 13 | Buffer write address |
| memWdata | output | 8 | Buffer write data |
| memWe | output | 1 | Buffer write enable |
| swapPorts | output | 1 | Arbiter port-swap request |

## Verification
The first write appears on the memory port in the cycle after the clock edge that accepts the start request. The write to location k follows k cycles after that. Busy reads 0 and the final checksum is readable in the cycle after the write to location 8191. The bench drives inputs and samples outputs on the falling edge. A behavioural model advances one expected byte per falling edge and compares address, data and enable in every cycle of a run. It checks busy, the control read-back and the checksum in the first idle cycle after the run.

// File: rtl/mstPkg.sv
`timescale 1ns/1ps
package mstPkg;
  typedef enum logic [1:0] {
    FILL_RAND  = 2'b00,
    FILL_ADDR  = 2'b01,
    FILL_SHIFT = 2'b10,
    FILL_RSVD  = 2'b11
  } fillMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // start accepted this cycle
    logic loadRand;  // the accepted start selects the random mode
    logic step;      // a location is written this cycle
  } dpStrobe_t;
endpackage

// File: rtl/mstCtrl.sv
`timescale 1ns/1ps
module mstCtrl
  import mstPkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [7:0]        ctrlRd,
  output logic [DATA_W-1:0] seedQ,
  output fillMode_e         modeQ,
  output logic [2:0]        shiftQ,
  output logic              swapPorts,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output dpStrobe_t         strobe
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [1:0] CTRL_SEL = 2'd0;
  localparam logic [1:0] SEED_SEL = 2'd1;

  logic              busy;
  logic              testEn;
  logic [ADDR_W-1:0] addrCnt;
  logic              ctrlWr;
  logic              startReq;
  fillMode_e         reqMode;

  assign ctrlWr   = regWr && (regAddr == CTRL_SEL) && !busy;
  assign reqMode  = fillMode_e'(regWdata[5:4]);
  assign startReq = ctrlWr && regWdata[7] && regWdata[6] && (reqMode != FILL_RSVD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      testEn    <= 1'b0;
      modeQ     <= FILL_RAND;
      shiftQ    <= '0;
      swapPorts <= 1'b0;
      seedQ     <= '0;
      addrCnt   <= '0;
    end else begin
      if (ctrlWr) begin
        testEn    <= regWdata[6];
        modeQ     <= reqMode;
        swapPorts <= regWdata[3];
        shiftQ    <= regWdata[2:0];
      end
      if (regWr && regAddr == SEED_SEL) seedQ <= regWdata;
      if (startReq) begin
        busy    <= 1'b1;
        addrCnt <= '0;
      end else if (busy) begin
        addrCnt <= addrCnt + 1'b1;
        if (addrCnt == LAST_ADDR) busy <= 1'b0;
      end
    end
  end

  assign ctrlRd          = {busy, testEn, modeQ, swapPorts, shiftQ};
  assign memAddr         = addrCnt;
  assign memWe           = busy;
  assign strobe.load     = startReq;
  assign strobe.loadRand = startReq && (reqMode == FILL_RAND);
  assign strobe.step     = busy;

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> addrCnt == $past(addrCnt) + 1'b1);
  // R3
  first_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> addrCnt == '0);
  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && $past(addrCnt) == LAST_ADDR) |-> !busy);
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> ($stable(modeQ) && $stable(shiftQ) && $stable(swapPorts)));
  // R10
  rsvd_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (modeQ != FILL_RSVD && testEn));
endmodule

// File: rtl/mstDatapath.sv
`timescale 1ns/1ps
module mstDatapath
  import mstPkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  LFSR_MASK = 8'hB8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  fillMode_e         modeIn,
  input  logic [2:0]        shiftIn,
  input  logic [DATA_W-1:0] seedIn,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] memWdata,
  output logic [15:0]       checksum
);
  logic [DATA_W-1:0] patQ;
  logic [DATA_W-1:0] lfsrNext;
  logic [DATA_W-1:0] rotNext;
  logic [15:0]       accQ;
  logic [15:0]       word;
  logic [16:0]       sumWide;
  logic [15:0]       accNext;

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v, input logic [2:0] n);
    logic [2*DATA_W-1:0] w;
    w = {v, v} << n;
    return w[2*DATA_W-1:DATA_W];
  endfunction

  always_comb begin
    lfsrNext = patQ >> 1;
    if (patQ[0]) lfsrNext = lfsrNext ^ LFSR_MASK;
  end

  assign rotNext  = rotl(patQ, shiftIn);
  assign memWdata = (modeIn == FILL_ADDR) ? addrIn[DATA_W-1:0] : patQ;
  assign word     = addrIn[0] ? {8'h00, memWdata} : {memWdata, 8'h00};
  assign sumWide  = {1'b0, accQ} + {1'b0, word};
  assign accNext  = sumWide[15:0] + {15'd0, sumWide[16]};
  assign checksum = ~accQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      patQ <= '0;
      accQ <= '0;
    end else if (strobe.load) begin
      patQ <= (strobe.loadRand && seedIn == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : seedIn;
      accQ <= '0;
    end else if (strobe.step) begin
      accQ <= accNext;
      unique case (modeIn)
        FILL_RAND:  patQ <= lfsrNext;
        FILL_SHIFT: patQ <= rotNext;
        default:    patQ <= patQ;
      endcase
    end
  end

  // R7
  shift_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.step) && modeIn == FILL_SHIFT) |-> patQ == rotl($past(patQ), shiftIn));
  // R5
  rand_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.load) && modeIn == FILL_RAND) |-> patQ != '0);
  // R9
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strobe.step) && !$past(strobe.load)) |-> $stable(checksum));
endmodule

// File: rtl/memSelfTest.sv
`timescale 1ns/1ps
module memSelfTest
  import mstPkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter logic [7:0]  LFSR_MASK = 8'hB8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              swapPorts
);
  dpStrobe_t         strobe;
  fillMode_e         modeQ;
  logic [2:0]        shiftQ;
  logic [DATA_W-1:0] seedQ;
  logic [7:0]        ctrlRd;
  logic [15:0]       checksum;

  mstCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .ctrlRd(ctrlRd), .seedQ(seedQ), .modeQ(modeQ), .shiftQ(shiftQ),
    .swapPorts(swapPorts), .memAddr(memAddr), .memWe(memWe), .strobe(strobe)
  );

  mstDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LFSR_MASK(LFSR_MASK)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeIn(modeQ), .shiftIn(shiftQ),
    .seedIn(seedQ), .addrIn(memAddr), .memWdata(memWdata), .checksum(checksum)
  );

  always_comb begin
    unique case (regAddr)
      2'd0:    regRdata = ctrlRd;
      2'd1:    regRdata = seedQ;
      2'd2:    regRdata = checksum[15:8];
      default: regRdata = checksum[7:0];
    endcase
  end
endmodule

// File: tb/memSelfTest_test.sv
`timescale 1ns/1ps
module memSelfTest_test;
  localparam int N = 8192;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic [12:0] memAddr;
  logic [7:0] memWdata;
  logic       memWe;
  logic       swapPorts;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  memSelfTest uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .swapPorts(swapPorts)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] v);
    regAddr = a;
    #0.5;
    v = regRdata;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // Run one test; ctrl must request a legal start. Optionally try a control
  // write halfway through (R11).
  task automatic runTest(input logic [7:0] ctrl, input logic [7:0] seed, input bit meddle, input string tag);
    int pat;
    int sum;
    logic [7:0] v;
    logic [7:0] b;
    writeReg(2'd1, seed);
    pat = (ctrl[5:4] == 2'b00 && seed == 0) ? 1 : seed;
    sum = 0;
    writeReg(2'd0, ctrl);
    for (int i = 0; i < N; i++) begin
      b = (ctrl[5:4] == 2'b01) ? i[7:0] : pat[7:0];
      chk(memWe === 1'b1 && memAddr === i[12:0] && memWdata === b,
          (ctrl[5:4] == 2'b00) ? "R5" : (ctrl[5:4] == 2'b01) ? "R6" : "R7",
          {"R3 write ", tag}, {memWe, memAddr, memWdata}, {1'b1, i[12:0], b});
      if (i == 0 || i == N/2) begin
        chk(swapPorts === ctrl[3], "R12", "swap during run", swapPorts, ctrl[3]);
        readReg(2'd0, v);
        chk(v[7] === 1'b1, "R4", "busy during run", v[7], 1);
      end
      if (i[0]) sum += b; else sum += b * 256;
      if (ctrl[5:4] == 2'b00) pat = (pat & 1) ? ((pat >> 1) ^ 'hB8) : (pat >> 1);
      else if (ctrl[5:4] == 2'b10) pat = ((pat << ctrl[2:0]) | (pat >> (8 - ctrl[2:0]))) & 'hFF;
      if (meddle && i == 100) begin
        regWr = 1'b1; regAddr = 2'd0; regWdata = {1'b1, 1'b1, 2'b01, ~ctrl[3], ~ctrl[2:0]};
        @(negedge clk);
        regWr = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    while (sum > 'hFFFF) sum = (sum & 'hFFFF) + (sum >> 16);
    sum = (~sum) & 'hFFFF;
    chk(memWe === 1'b0, "R3", {"write stops ", tag}, memWe, 0);
    readReg(2'd0, v);
    chk(v === {1'b0, ctrl[6:0]}, meddle ? "R11" : "R4", {"ctrl after ", tag}, v, {1'b0, ctrl[6:0]});
    readReg(2'd2, v);
    chk(v === sum[15:8], "R9", {"sum hi ", tag}, v, sum[15:8]);
    readReg(2'd3, v);
    chk(v === sum[7:0], "R9", {"sum lo ", tag}, v, sum[7:0]);
  endtask

  task automatic tryIgnored(input logic [7:0] ctrl, input string tag);
    logic [7:0] v;
    writeReg(2'd0, ctrl);
    for (int i = 0; i < 4; i++) begin
      chk(memWe === 1'b0, "R10", {"no write ", tag}, memWe, 0);
      @(negedge clk);
    end
    readReg(2'd0, v);
    chk(v === {1'b0, ctrl[6:0]}, "R10", {"idle ", tag}, v, {1'b0, ctrl[6:0]});
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    readReg(2'd0, v); chk(v === 8'h00, "R1", "ctrl reset", v, 0);
    readReg(2'd1, v); chk(v === 8'h00, "R1", "seed reset", v, 0);
    readReg(2'd2, v); chk(v === 8'hFF, "R1", "sum hi reset", v, 'hFF);
    readReg(2'd3, v); chk(v === 8'hFF, "R1", "sum lo reset", v, 'hFF);
    chk(memWe === 1'b0 && swapPorts === 1'b0, "R1", "outputs reset", {memWe, swapPorts}, 0);
    // R2 seed read-back
    writeReg(2'd1, 8'hC3);
    readReg(2'd1, v); chk(v === 8'hC3, "R2", "seed readback", v, 'hC3);
    // R10 ignored starts
    tryIgnored(8'b1000_0000, "enable clear");
    tryIgnored(8'b1111_0000, "reserved mode");
    // R5 zero seed, R8 shift ignored in random mode
    runTest(8'b1100_0101, 8'h00, 1'b0, "rand seed0");
    runTest(8'b1100_0000, 8'h5A, 1'b0, "rand seed5A");
    // R6 address fill with shift set (R8)
    runTest(8'b1101_0111, 8'h33, 1'b0, "addr");
    // R7 shift fill, R11 meddling, R12 swap
    runTest(8'b1110_1011, 8'h81, 1'b1, "shift3");
    chk(swapPorts === 1'b1, "R12", "swap after run", swapPorts, 1);
    runTest(8'b1110_0000, 8'hA5, 1'b0, "shift0");
    chk(swapPorts === 1'b0, "R12", "swap cleared", swapPorts, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule